// File: doc/BRIEF.md
# Region Access Protection Checker

This block screens every processor access against a small set of programmable address regions. It returns the protection attributes that apply, a one-cycle fault pulse for forbidden accesses, and a stall flag for speculative accesses that must wait. Instruction fetches are compared only against a bank of four fetch regions. Data loads and stores are compared only against a separate bank of four data regions.

Each region has a size-aligned base address and a power-of-two size from 4 KB to 16 MB. It also has an enable bit and three attribute bits: supervisor-only, write-protect and speculation-allowed. An access that hits no enabled region in its bank takes its attributes from one global default entry, which both banks share.

Regions and the default entry are loaded through a single-cycle register write port. Every access gets a registered response on the clock edge that follows it.

Top module: `rgn_guard`

## Requirements
- R1: Fetch accesses (`acc_is_fetch`=1) are compared only with the fetch bank (`cfg_addr[3]`=0), and data accesses only with the data bank (`cfg_addr[3]`=1). A region in one bank never matches an access of the other kind.
- R2: The size code in `cfg_wdata[7:4]` gives a region size of 4 KB shifted left by the code, for codes 0 to 12. Codes above 12 act as 12 (16 MB). A match compares only the address bits above the region size, so base bits below the size are ignored.
- R3: When several enabled regions of one bank match, `rsp_region` reports the lowest index and `rsp_attr` takes that region's attributes. A region whose enable bit `cfg_wdata[3]` is 0 never matches.
- R4: An access that matches no enabled region in its bank gives `rsp_hit`=0 and `rsp_region`=0, and takes the default entry's attributes, which are written with `cfg_addr[2]`=1. Faults and stalls follow those attributes.
- R5: A user access (`acc_user`=1) that resolves to attributes with the supervisor-only bit (`attr[0]`) set raises `fault` for exactly one cycle.
- R6: A data write that resolves to attributes with the write-protect bit (`attr[1]`) set raises `fault`. Data reads and all fetches never fault on that bit.
- R7: A speculative access (`acc_spec`=1) whose attributes have the speculation-allowed bit (`attr[2]`) clear raises `spec_stall` and does not raise `fault`, even if it would otherwise violate R5 or R6.
- R8: A region or default write takes effect on the cycle after the write. An access in the same cycle as the write is checked against the old contents.
- R9: After reset, all regions are disabled, the default entry grants full access (`attr`=3'b100), and every response output is 0.
- R10: Every response output is registered. `rsp_valid` follows `acc_valid` by one cycle, and `rsp_valid`, `fault` and `spec_stall` stay 0 in the cycle after an idle input cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | [3] selects the data bank, [2] selects the default entry, [1:0] is the region index |
| cfg_wdata | input | 28 | [27:8] base address bits 31:12, [7:4] size code, [3] enable, [2:0] attributes {spec_ok, wr_prot, sup_only} |
| acc_valid | input | 1 | Access present this cycle |
| acc_is_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | Data write (ignored for fetches) |
| acc_user | input | 1 | Access made in user mode |
| acc_spec | input | 1 | Access is speculative |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_hit | output | 1 | An enabled region matched |
| rsp_region | output | 2 | Winning region index |
| rsp_attr | output | 3 | Attributes that applied |
| fault | output | 1 | Protection violation pulse |
| spec_stall | output | 1 | Speculative access must be held back |

## Verification
The bench probes the two ends of the size range: the first and last addresses inside a 64 KB region, a base with stray low bits, and a size code above 12. A design that got the mask wrong would miss the edge address, match the next block, or wrap the size. It sets up overlapping regions, then disables the winner, so an encoder that picked the highest index or ignored the enable would report the wrong region. It drives an access in the same cycle as the write that changes its region. A design that bypassed the new value would hit one cycle early. Speculative accesses that also break the privilege rules must stall rather than fault, and fetches marked as writes must never trip write protection.

// File: rtl/rgn_guard_pkg.sv
package rgn_guard_pkg;
  localparam int ADDR_W    = 32;
  localparam int MIN_SHIFT = 12;
  localparam int CODE_W    = 4;
  localparam int ATTR_W    = 3;
  localparam int BASE_W    = ADDR_W - MIN_SHIFT;
  localparam int CFG_W     = BASE_W + CODE_W + 1 + ATTR_W;

  typedef struct packed {
    logic spec_ok;
    logic wr_prot;
    logic sup_only;
  } attr_t;

  localparam attr_t FULL_ACCESS = '{spec_ok: 1'b1, wr_prot: 1'b0, sup_only: 1'b0};

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [CODE_W-1:0] code;
    logic              en;
    attr_t             attr;
  } rgn_t;

  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c,
                                                   input int max_code);
    return (int'(c) > max_code) ? CODE_W'(max_code) : c;
  endfunction

  function automatic rgn_t unpack_cfg(input logic [CFG_W-1:0] w, input int max_code);
    rgn_t r;
    r.base = w[CFG_W-1 -: BASE_W];
    r.code = clamp_code(w[ATTR_W+1 +: CODE_W], max_code);
    r.en   = w[ATTR_W];
    r.attr = attr_t'(w[ATTR_W-1:0]);
    return r;
  endfunction

  // Ones on every address bit that must equal the base
  function automatic logic [ADDR_W-1:0] keep_mask(input logic [CODE_W-1:0] code);
    return {ADDR_W{1'b1}} << (MIN_SHIFT + int'(code));
  endfunction

  function automatic logic addr_in(input logic [ADDR_W-1:0] addr, input rgn_t r);
    logic [ADDR_W-1:0] full_base;
    full_base = {r.base, {MIN_SHIFT{1'b0}}};
    return r.en && (((addr ^ full_base) & keep_mask(r.code)) == '0);
  endfunction
endpackage

// File: rtl/rgn_cfg_bank.sv
module rgn_cfg_bank
  import rgn_guard_pkg::*;
#(
  parameter int NUM_RGN  = 4,
  parameter int MAX_CODE = 12,
  localparam int IDX_W   = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [CFG_W-1:0]       wr_data,
  output rgn_t [NUM_RGN-1:0]     regs
);
  for (genvar i = 0; i < NUM_RGN; i++) begin : g_rgn
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[i] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        regs[i] <= unpack_cfg(wr_data, MAX_CODE);
      end
    end
  end
endmodule

// File: rtl/rgn_match.sv
module rgn_match
  import rgn_guard_pkg::*;
#(
  parameter int NUM_RGN = 4,
  localparam int IDX_W  = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
  input  logic [ADDR_W-1:0]   addr,
  input  rgn_t [NUM_RGN-1:0]  regs,
  output logic                any_hit,
  output logic [IDX_W-1:0]    win_idx,
  output attr_t               win_attr
);
  logic [NUM_RGN-1:0] hit_vec;

  for (genvar i = 0; i < NUM_RGN; i++) begin : g_cmp
    assign hit_vec[i] = addr_in(addr, regs[i]);
  end

  // Scan from the top so the lowest matching index is written last
  always_comb begin
    win_idx = '0;
    for (int i = NUM_RGN - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = IDX_W'(i);
    end
  end

  assign any_hit  = |hit_vec;
  assign win_attr = any_hit ? regs[win_idx].attr : '0;
endmodule

// File: rtl/rgn_verdict.sv
module rgn_verdict
  import rgn_guard_pkg::*;
#(
  parameter int NUM_RGN = 4,
  localparam int IDX_W  = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_is_fetch,
  input  logic             acc_write,
  input  logic             acc_user,
  input  logic             acc_spec,
  input  logic             f_hit,
  input  logic [IDX_W-1:0] f_idx,
  input  attr_t            f_attr,
  input  logic             d_hit,
  input  logic [IDX_W-1:0] d_idx,
  input  attr_t            d_attr,
  input  attr_t            dflt_attr,
  output logic             sup_viol,
  output logic             wp_viol,
  output logic             spec_blk,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_region,
  output attr_t            rsp_attr,
  output logic             fault,
  output logic             spec_stall
);
  logic             sel_hit;
  logic [IDX_W-1:0] sel_idx;
  attr_t            eff_attr;

  always_comb begin
    if (acc_is_fetch) begin
      sel_hit = f_hit;
      sel_idx = f_idx;
    end else begin
      sel_hit = d_hit;
      sel_idx = d_idx;
    end
    if (!sel_hit) begin
      eff_attr = dflt_attr;
    end else if (acc_is_fetch) begin
      eff_attr = f_attr;
    end else begin
      eff_attr = d_attr;
    end
  end

  assign spec_blk = acc_valid && acc_spec && !eff_attr.spec_ok;
  assign sup_viol = acc_valid && !spec_blk && acc_user && eff_attr.sup_only;
  assign wp_viol  = acc_valid && !spec_blk && !acc_is_fetch && acc_write && eff_attr.wr_prot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
      rsp_attr   <= '0;
      fault      <= 1'b0;
      spec_stall <= 1'b0;
    end else begin
      rsp_valid  <= acc_valid;
      rsp_hit    <= acc_valid && sel_hit;
      rsp_region <= (acc_valid && sel_hit) ? sel_idx : '0;
      rsp_attr   <= acc_valid ? eff_attr : '0;
      fault      <= sup_viol || wp_viol;
      spec_stall <= spec_blk;
    end
  end
endmodule

// File: rtl/rgn_guard.sv
module rgn_guard
  import rgn_guard_pkg::*;
#(
  parameter int NUM_RGN  = 4,
  parameter int MAX_CODE = 12,
  localparam int IDX_W   = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W+1:0]   cfg_addr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               acc_valid,
  input  logic               acc_is_fetch,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic               acc_write,
  input  logic               acc_user,
  input  logic               acc_spec,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [IDX_W-1:0]   rsp_region,
  output logic [ATTR_W-1:0]  rsp_attr,
  output logic               fault,
  output logic               spec_stall
);
  localparam int DATA_SEL_BIT = IDX_W + 1;
  localparam int DFLT_SEL_BIT = IDX_W;

  // Decoded write strobes
  logic fetch_wr_w, data_wr_w, dflt_wr_w;
  assign dflt_wr_w  = cfg_we && cfg_addr[DFLT_SEL_BIT];
  assign fetch_wr_w = cfg_we && !cfg_addr[DFLT_SEL_BIT] && !cfg_addr[DATA_SEL_BIT];
  assign data_wr_w  = cfg_we && !cfg_addr[DFLT_SEL_BIT] &&  cfg_addr[DATA_SEL_BIT];

  rgn_t [NUM_RGN-1:0] fetch_regs, data_regs;
  attr_t              dflt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         dflt_q <= FULL_ACCESS;
    else if (dflt_wr_w) dflt_q <= attr_t'(cfg_wdata[ATTR_W-1:0]);
  end

  rgn_cfg_bank #(.NUM_RGN(NUM_RGN), .MAX_CODE(MAX_CODE)) u_fetch_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(fetch_wr_w),
    .wr_idx(cfg_addr[IDX_W-1:0]), .wr_data(cfg_wdata), .regs(fetch_regs)
  );

  rgn_cfg_bank #(.NUM_RGN(NUM_RGN), .MAX_CODE(MAX_CODE)) u_data_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr_w),
    .wr_idx(cfg_addr[IDX_W-1:0]), .wr_data(cfg_wdata), .regs(data_regs)
  );

  // Match results, one set per bank
  logic             f_hit_w, d_hit_w;
  logic [IDX_W-1:0] f_idx_w, d_idx_w;
  attr_t            f_attr_w, d_attr_w;

  rgn_match #(.NUM_RGN(NUM_RGN)) u_fetch_match (
    .addr(acc_addr), .regs(fetch_regs),
    .any_hit(f_hit_w), .win_idx(f_idx_w), .win_attr(f_attr_w)
  );

  rgn_match #(.NUM_RGN(NUM_RGN)) u_data_match (
    .addr(acc_addr), .regs(data_regs),
    .any_hit(d_hit_w), .win_idx(d_idx_w), .win_attr(d_attr_w)
  );

  // Violation events, brought out for the checker
  logic  sup_viol_w, wp_viol_w, spec_blk_w;
  attr_t rsp_attr_s;

  rgn_verdict #(.NUM_RGN(NUM_RGN)) u_verdict (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_is_fetch(acc_is_fetch), .acc_write(acc_write),
    .acc_user(acc_user), .acc_spec(acc_spec),
    .f_hit(f_hit_w), .f_idx(f_idx_w), .f_attr(f_attr_w),
    .d_hit(d_hit_w), .d_idx(d_idx_w), .d_attr(d_attr_w),
    .dflt_attr(dflt_q),
    .sup_viol(sup_viol_w), .wp_viol(wp_viol_w), .spec_blk(spec_blk_w),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_region(rsp_region),
    .rsp_attr(rsp_attr_s), .fault(fault), .spec_stall(spec_stall)
  );

  assign rsp_attr = rsp_attr_s;
endmodule

// File: rtl/rgn_guard_chk.sv
module rgn_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic acc_valid,
  input logic acc_is_fetch,
  input logic acc_write,
  input logic acc_spec,
  input logic rsp_valid,
  input logic fault,
  input logic spec_stall,
  input logic sup_viol_w,
  input logic wp_viol_w,
  input logic spec_blk_w
);
  assert_stall_not_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault && spec_stall));

  assert_stall_needs_spec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spec_stall |-> $past(acc_spec) && $past(acc_valid));

  assert_blk_excludes_viol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spec_blk_w |-> !sup_viol_w && !wp_viol_w);

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid && !fault && !spec_stall);

  assert_fault_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(sup_viol_w) || $past(wp_viol_w));

  assert_wp_data_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wp_viol_w |-> acc_valid && !acc_is_fetch && acc_write);
endmodule

bind rgn_guard rgn_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_fetch(acc_is_fetch),
  .acc_write(acc_write), .acc_spec(acc_spec), .rsp_valid(rsp_valid),
  .fault(fault), .spec_stall(spec_stall), .sup_viol_w(sup_viol_w),
  .wp_viol_w(wp_viol_w), .spec_blk_w(spec_blk_w)
);

// File: tb/rgn_guard_tb.sv
`timescale 1ns/1ps
module rgn_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [27:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0, acc_is_fetch = 1'b0, acc_write = 1'b0;
  logic        acc_user = 1'b0, acc_spec = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        rsp_valid, rsp_hit, fault, spec_stall;
  logic [1:0]  rsp_region;
  logic [2:0]  rsp_attr;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rgn_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_is_fetch(acc_is_fetch), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_user(acc_user), .acc_spec(acc_spec),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_region(rsp_region),
    .rsp_attr(rsp_attr), .fault(fault), .spec_stall(spec_stall)
  );

  // Bank select: 0 fetch, 1 data
  function automatic logic [27:0] rgn_word(input logic [31:0] base, input logic [3:0] code,
                                           input logic en, input logic [2:0] attr);
    return {base[31:12], code, en, attr};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [27:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive_acc(input logic f, input logic [31:0] a, input logic w,
                           input logic u, input logic s);
    acc_valid = 1'b1; acc_is_fetch = f; acc_addr = a;
    acc_write = w; acc_user = u; acc_spec = s;
  endtask

  // One access; the response is registered, so sample at the next falling edge
  task automatic do_acc(input logic f, input logic [31:0] a, input logic w,
                        input logic u, input logic s);
    @(negedge clk);
    drive_acc(f, a, w, u, s);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic hit, input logic [1:0] idx,
                            input logic [2:0] attr, input logic flt, input logic stl);
    check(req, "rsp_valid", 32'(rsp_valid), 32'd1);
    check(req, "rsp_hit", 32'(rsp_hit), 32'(hit));
    check(req, "rsp_region", 32'(rsp_region), 32'(idx));
    check(req, "rsp_attr", 32'(rsp_attr), 32'(attr));
    check(req, "fault", 32'(fault), 32'(flt));
    check(req, "spec_stall", 32'(spec_stall), 32'(stl));
  endtask

  task automatic t_reset;
    check("R9", "rsp_valid", 32'(rsp_valid), 0);
    check("R9", "fault", 32'(fault), 0);
    check("R9", "spec_stall", 32'(spec_stall), 0);
    do_acc(0, 32'h0000_1000, 0, 1, 1);
    expect_rsp("R9", 0, 0, 3'b100, 0, 0);
    do_acc(1, 32'hFFFF_F000, 0, 1, 1);
    expect_rsp("R4", 0, 0, 3'b100, 0, 0);
  endtask

  task automatic t_write_timing;
    // data region 0: 4 KB at 0x10000, supervisor-only
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'b1000; cfg_wdata = rgn_word(32'h0001_0000, 4'd0, 1, 3'b001);
    drive_acc(0, 32'h0001_0010, 0, 0, 0);
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    expect_rsp("R8", 0, 0, 3'b100, 0, 0);
    do_acc(0, 32'h0001_0010, 0, 0, 0);
    expect_rsp("R8", 1, 0, 3'b001, 0, 0);
  endtask

  task automatic t_separation;
    do_acc(1, 32'h0001_0010, 0, 1, 0);
    expect_rsp("R1", 0, 0, 3'b100, 0, 0);
    cfg_wr(4'b0001, rgn_word(32'h0080_0000, 4'd0, 1, 3'b110));
    do_acc(0, 32'h0080_0000, 0, 0, 0);
    expect_rsp("R1", 0, 0, 3'b100, 0, 0);
    do_acc(1, 32'h0080_0FFC, 0, 0, 0);
    expect_rsp("R1", 1, 1, 3'b110, 0, 0);
  endtask

  task automatic t_sizes;
    cfg_wr(4'b1001, rgn_word(32'h0020_0000, 4'd4, 1, 3'b100));   // 64 KB
    do_acc(0, 32'h0020_FFFC, 0, 0, 0);
    expect_rsp("R2", 1, 1, 3'b100, 0, 0);
    do_acc(0, 32'h0021_0000, 0, 0, 0);
    expect_rsp("R2", 0, 0, 3'b100, 0, 0);
    do_acc(0, 32'h001F_FFFC, 0, 0, 0);
    expect_rsp("R2", 0, 0, 3'b100, 0, 0);
    cfg_wr(4'b1010, rgn_word(32'h0050_3000, 4'd8, 1, 3'b100));   // 1 MB, stray low base bits
    do_acc(0, 32'h0050_0000, 0, 0, 0);
    expect_rsp("R2", 1, 2, 3'b100, 0, 0);
    cfg_wr(4'b0011, rgn_word(32'h0100_0000, 4'd15, 1, 3'b100));  // code 15 acts as 16 MB
    do_acc(1, 32'h01FF_FFF0, 0, 0, 0);
    expect_rsp("R2", 1, 3, 3'b100, 0, 0);
    do_acc(1, 32'h0200_0000, 0, 0, 0);
    expect_rsp("R2", 0, 0, 3'b100, 0, 0);
  endtask

  task automatic t_priority;
    cfg_wr(4'b1011, rgn_word(32'h0000_0000, 4'd12, 1, 3'b010));  // 16 MB, write-protect
    do_acc(0, 32'h0020_0100, 0, 0, 0);
    expect_rsp("R3", 1, 1, 3'b100, 0, 0);
    do_acc(0, 32'h0030_0000, 0, 0, 0);
    expect_rsp("R3", 1, 3, 3'b010, 0, 0);
    do_acc(0, 32'h0001_0004, 0, 0, 0);
    expect_rsp("R3", 1, 0, 3'b001, 0, 0);
    cfg_wr(4'b1001, rgn_word(32'h0020_0000, 4'd4, 0, 3'b100));   // disable region 1
    do_acc(0, 32'h0020_0100, 0, 0, 0);
    expect_rsp("R3", 1, 3, 3'b010, 0, 0);
  endtask

  task automatic t_supervisor;
    do_acc(0, 32'h0001_0004, 0, 1, 0);
    expect_rsp("R5", 1, 0, 3'b001, 1, 0);
    @(negedge clk);
    check("R5", "fault pulse width", 32'(fault), 0);
    do_acc(0, 32'h0001_0004, 0, 0, 0);
    expect_rsp("R5", 1, 0, 3'b001, 0, 0);
  endtask

  task automatic t_write_protect;
    do_acc(0, 32'h0030_0000, 1, 0, 0);
    expect_rsp("R6", 1, 3, 3'b010, 1, 0);
    do_acc(0, 32'h0030_0000, 0, 0, 0);
    expect_rsp("R6", 1, 3, 3'b010, 0, 0);
    cfg_wr(4'b0000, rgn_word(32'h0040_0000, 4'd0, 1, 3'b110));
    do_acc(1, 32'h0040_0010, 1, 0, 0);
    expect_rsp("R6", 1, 0, 3'b110, 0, 0);
  endtask

  task automatic t_speculative;
    do_acc(0, 32'h0001_0004, 0, 1, 1);          // would fault, but stalls
    expect_rsp("R7", 1, 0, 3'b001, 0, 1);
    do_acc(0, 32'h0030_0000, 1, 0, 1);          // write-protect + no spec
    expect_rsp("R7", 1, 3, 3'b010, 0, 1);
    do_acc(1, 32'h0040_0000, 0, 0, 1);          // spec allowed
    expect_rsp("R7", 1, 0, 3'b110, 0, 0);
  endtask

  task automatic t_default;
    cfg_wr(4'b0100, 28'h000_0001);              // default: supervisor-only, no spec
    do_acc(0, 32'h0300_0000, 0, 1, 0);
    expect_rsp("R4", 0, 0, 3'b001, 1, 0);
    do_acc(1, 32'h0300_0000, 0, 0, 1);
    expect_rsp("R4", 0, 0, 3'b001, 0, 1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    check("R10", "rsp_valid idle", 32'(rsp_valid), 0);
    check("R10", "fault idle", 32'(fault), 0);
    check("R10", "spec_stall idle", 32'(spec_stall), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_timing();
    t_separation();
    t_sizes();
    t_priority();
    t_supervisor();
    t_write_protect();
    t_speculative();
    t_default();
    t_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule